// File: doc/BRIEF.md
# Backplane Source Selector with Divide-by-16

This block drives the common backplane line of a static segment display driver. The line can come from either of two sources. One is a local oscillator clock, which is divided down inside the block. The other is a backplane signal supplied from outside, which is passed straight through. Chained drivers use this second path to share one backplane.

No control input picks the source. After reset is released, the block watches the oscillator input. If the oscillator stays quiet, the output follows the external backplane input. The first rising edge seen on the oscillator input switches the block to the divided clock. That choice then holds until the next reset, even if the oscillator stops later.

The oscillator input is treated as a slow digital level. It is sampled by the system clock through a synchroniser, and each detected rising edge advances a small divider. The most significant bit of that divider is the internal backplane.

Top module: `bpsel_top`

## Requirements
- R1: While `rst_n` is low, `bp_out` is 0 and `int_mode` is 0, whatever `osc_in` and `bp_ext_in` do.
- R2: After reset release, as long as no rising edge has been detected on `osc_in`, `int_mode` is 0 and `bp_out` equals `bp_ext_in` in the same cycle (no register on this path with the default `EXT_REGISTERED = 0`).
- R3: The first rising edge of `osc_in` after reset release sets `int_mode` to 1 (1 = internal source, 0 = external source). This takes effect no more than 4 system clock cycles after `osc_in` rises.
- R4: In internal mode, `bp_out` is bit 3 (the MSB) of a 4-bit counter. Reset sets the counter to 0, and each detected `osc_in` rising edge adds 1, counting the edge that selects the mode. So `bp_out` is 0 after 1 to 7 edges, 1 after 8 to 15 edges, 0 after 16 edges and 1 again after 24 edges. This gives a period of 16 oscillator periods at 50% duty.
- R5: In internal mode, `bp_ext_in` has no effect on `bp_out`.
- R6: Once set, `int_mode` stays 1 until the next reset, even if `osc_in` stops. While no oscillator edge arrives, `bp_out` holds its level.
- R7: Reset clears both the divider and the mode selection. A run after reset that sees no oscillator edge is back in external mode, and edges counted before the reset do not carry over.
- R8: `osc_in` passes through two synchroniser flops before edge detection. A high level of any length on `osc_in` counts as exactly one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the oscillator input |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_in | input | 1 | Oscillator clock, or held low when no local oscillator is fitted |
| bp_ext_in | input | 1 | Externally supplied backplane signal |
| bp_out | output | 1 | Backplane output to the segment drivers |
| int_mode | output | 1 | Latched source: 1 internal divided clock, 0 external pass-through |

## Verification
A vector table applies 1, 7, 8, 15, 16 and 24 oscillator edges, each after a fresh reset. These counts sit on both sides of each divider MSB transition, so a wrong division ratio or an off-by-one in counting the mode-selecting edge shows up as a wrong level. With no oscillator edge at all, the external input is toggled both ways to show it is passed through. In internal mode the external input is toggled to show it is ignored. Further patterns cover:
- a single long high pulse, which separates level detection from edge detection;
- an oscillator that stops after selection, which shows the mode is sticky;
- a reset in the middle of a count, which shows the divider is cleared rather than resumed.

// File: rtl/bpsel_pkg.sv
package bpsel_pkg;

   typedef enum logic {
      BP_SRC_EXT = 1'b0,
      BP_SRC_INT = 1'b1
   } bp_src_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/bpsel_sync.sv
module bpsel_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("bpsel_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q[i] <= RST_VAL;
         end else begin
            if (i == 0) begin
               chain_q[i] <= d_in;
            end else begin
               chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
            end
         end
      end
   end

   assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/bpsel_edge.sv
module bpsel_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_in,
   output logic rise_pulse
);
   logic lvl_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_prev_q <= 1'b0;
      end else begin
         lvl_prev_q <= lvl_in;
      end
   end

   assign rise_pulse = lvl_in & ~lvl_prev_q;
endmodule

// File: rtl/bpsel_divider.sv
module bpsel_divider #(
   parameter int unsigned DIV_RATIO = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic div_msb
);
   import bpsel_pkg::*;

   localparam int unsigned CNT_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;

   if (!is_pow2(DIV_RATIO) || DIV_RATIO < 2) begin : g_bad_ratio
      $error("bpsel_divider: DIV_RATIO must be a power of two of at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign div_msb = cnt_q[CNT_W-1];
endmodule

// File: rtl/bpsel_mode.sv
module bpsel_mode (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   output bpsel_pkg::bp_src_e src
);
   import bpsel_pkg::*;

   bp_src_e src_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= BP_SRC_EXT;
      end else if (tick) begin
         src_q <= BP_SRC_INT;
      end
   end

   assign src = src_q;
endmodule

// File: rtl/bpsel_top.sv
module bpsel_top #(
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned DIV_RATIO      = 16,
   parameter bit          EXT_REGISTERED = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_in,
   input  logic bp_ext_in,
   output logic bp_out,
   output logic int_mode
);
   import bpsel_pkg::*;

   logic    osc_sync;
   logic    osc_tick;
   logic    div_bp;
   logic    ext_bp;
   bp_src_e src_sel;

   bpsel_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (osc_in),
      .q_out (osc_sync)
   );

   bpsel_edge u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl_in     (osc_sync),
      .rise_pulse (osc_tick)
   );

   bpsel_divider #(.DIV_RATIO(DIV_RATIO)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (osc_tick),
      .div_msb (div_bp)
   );

   bpsel_mode u_mode (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (osc_tick),
      .src   (src_sel)
   );

   if (EXT_REGISTERED) begin : g_ext_reg
      logic ext_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ext_q <= 1'b0;
         end else begin
            ext_q <= bp_ext_in;
         end
      end
      assign ext_bp = ext_q;
   end else begin : g_ext_comb
      assign ext_bp = bp_ext_in;
   end

   always_comb begin
      if (!rst_n) begin
         bp_out = 1'b0;
      end else if (src_sel == BP_SRC_INT) begin
         bp_out = div_bp;
      end else begin
         bp_out = ext_bp;
      end
   end

   assign int_mode = (src_sel == BP_SRC_INT);
endmodule

// File: rtl/bpsel_checker.sv
module bpsel_checker #(
   parameter bit EXT_REGISTERED = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic osc_tick,
   input logic bp_ext_in,
   input logic bp_out,
   input logic int_mode
);
   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!bp_out && !int_mode); // R1
      end
   end

   AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      int_mode |=> int_mode); // R6

   AST_MODE_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_mode) |-> $past(osc_tick)); // R3

   AST_OUT_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (int_mode && $past(int_mode) && (bp_out != $past(bp_out))) |-> $past(osc_tick)); // R5

   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      osc_tick |=> !osc_tick); // R8

   if (!EXT_REGISTERED) begin : g_ext_follow
      AST_EXT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
         !int_mode |-> (bp_out == bp_ext_in)); // R2
   end
endmodule

bind bpsel_top bpsel_checker #(.EXT_REGISTERED(EXT_REGISTERED)) u_bpsel_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .osc_tick  (osc_tick),
   .bp_ext_in (bp_ext_in),
   .bp_out    (bp_out),
   .int_mode  (int_mode)
);

// File: tb/bpsel_tb.sv
module bpsel_top_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic osc_in = 1'b0;
   logic bp_ext_in = 1'b0;
   logic bp_out;
   logic int_mode;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bpsel_top dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .osc_in    (osc_in),
      .bp_ext_in (bp_ext_in),
      .bp_out    (bp_out),
      .int_mode  (int_mode)
   );

   localparam int NVEC = 6;
   localparam int VEC_EDGES [NVEC] = '{1, 7, 8, 15, 16, 24};
   localparam bit VEC_BP    [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};

   task automatic check(input logic got, input logic exp, input string req);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %0b expected %0b", req, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      osc_in = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic osc_edges(input int n);
      for (int i = 0; i < n; i++) begin
         osc_in = 1'b1;
         repeat (4) @(negedge clk);
         osc_in = 1'b0;
         repeat (4) @(negedge clk);
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: reset holds the output low with activity on both inputs
      bp_ext_in = 1'b1;
      repeat (2) @(negedge clk);
      osc_in = 1'b1;
      repeat (3) @(negedge clk);
      check(bp_out, 1'b0, "R1 bp_out in reset");
      check(int_mode, 1'b0, "R1 int_mode in reset");
      osc_in = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2: pass-through with no oscillator edge
      check(int_mode, 1'b0, "R2 mode external");
      bp_ext_in = 1'b1;
      #1;
      check(bp_out, 1'b1, "R2 follow ext high");
      bp_ext_in = 1'b0;
      #1;
      check(bp_out, 1'b0, "R2 follow ext low");
      repeat (20) @(negedge clk);
      check(int_mode, 1'b0, "R2 still external");

      // R4, R5: vector table of edge counts
      for (int v = 0; v < NVEC; v++) begin
         do_reset();
         bp_ext_in = 1'b1;
         osc_edges(VEC_EDGES[v]);
         check(int_mode, 1'b1, "R3 mode internal");
         check(bp_out, VEC_BP[v], "R4 divider level");
         bp_ext_in = ~bp_ext_in;
         @(negedge clk);
         check(bp_out, VEC_BP[v], "R5 ext ignored");
      end

      // R3: selection latency
      do_reset();
      osc_in = 1'b1;
      repeat (4) @(negedge clk);
      check(int_mode, 1'b1, "R3 latency 4 cycles");
      osc_in = 1'b0;
      repeat (4) @(negedge clk);

      // R6: oscillator stops, mode and level hold
      osc_edges(8);
      repeat (200) @(negedge clk);
      check(int_mode, 1'b1, "R6 mode sticky");
      check(bp_out, 1'b1, "R6 level held");

      // R7: reset mid-count clears divider and mode
      do_reset();
      osc_edges(3);
      do_reset();
      check(int_mode, 1'b0, "R7 mode cleared");
      bp_ext_in = 1'b1;
      #1;
      check(bp_out, 1'b1, "R7 external again");
      osc_edges(7);
      check(bp_out, 1'b0, "R7 divider cleared");

      // R8: long high level counts once
      do_reset();
      osc_in = 1'b1;
      repeat (30) @(negedge clk);
      osc_in = 1'b0;
      repeat (4) @(negedge clk);
      osc_edges(6);
      check(bp_out, 1'b0, "R8 long pulse single count");
      osc_edges(1);
      check(bp_out, 1'b1, "R8 eighth edge");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule